// File: doc/BRIEF.md
# CAM Command Decoder

This block is the control front end of a content-addressable memory. Each bus cycle is marked by an active-low cycle strobe. The decoder samples a 32-bit data bus, a 12-bit address/control bus, a control-select line, an active-low write enable and a validity input. It turns the cycle into a single operation for the CAM core. The operation classes are: memory access, register access, data move, compare, set validity, lookup-table control and initialization. The result is a one-cycle operation pulse, together with the operation class, the direction, the memory address or register index, the captured data word and the validity bit to store.

A configuration register inside the decoder holds the persistent mode. In hardware mode the control-select line chooses how the address/control bus is read. When the line is low, the bus is a direct memory address. When it is high, the bus carries an opcode and an operand. In software mode the opcode comes from an instruction register instead, and that register is loaded over the data bus. The control-select line then tells an instruction load apart from a data cycle. In software mode, memory can only be reached through the address register that the decoder keeps. The CAM core reads and writes the other registers (comparand, masks, status, device select) through the register operations this block issues.

Top module: `cam_cmd_dec`

## Requirements
- R1: A strobe assertion is the first rising edge at which `cyc_n` is sampled low after it was sampled high. It produces exactly one `op_valid` pulse, or one `illegal` pulse, which is visible in the cycle after that edge. Holding `cyc_n` low for more cycles produces nothing further.
- R2: In hardware mode, a strobe with `ac_is_ctl` low is a direct memory access. It gives `op_kind` 0, `op_addr` = `ac`, `op_write` = not `wr_n` and `op_data` = `dq`.
- R3: A direct memory write sets `op_vbit` to the `vld_ctl` value sampled with it. A memory read reports `op_vbit` 0.
- R4: In hardware mode, a strobe with `ac_is_ctl` high takes its opcode from `ac[3:0]` and its register index from `ac[7:4]`. The opcodes are: 0 memory (indirect), 1 register, 2 move, 3 compare, 4 set validity, 5 table control, 6 initialize. `op_kind` reports that code.
- R5: The register indices are: 0 comparand, 1 to 7 masks, 8 configuration, 9 status, 10 address, 11 device select, 12 instruction. A register write to index 8 loads the configuration from `dq`: bit 0 is software mode, bit 1 is table enable, bits 4:2 are mask select. The new values show on the `cfg_*` ports in the cycle after the decoding edge. Index 10 loads the address register from `dq[11:0]`, and index 12 loads the instruction register from `dq[7:0]`.
- R6: In software mode, a strobe with `ac_is_ctl` high and `wr_n` low loads the instruction register from `dq[7:0]` (opcode in bits 3:0, register index in bits 7:4) and issues no pulse. The same strobe with `wr_n` high does nothing. A strobe with `ac_is_ctl` low executes the held instruction with `dq` as data and `wr_n` as direction. `ac` is ignored.
- R7: Opcode 0, and any memory operation in software mode, uses the address register as `op_addr`.
- R8: Opcodes 7 to 15, and register operations with an index of 13 to 15, produce no `op_valid`. They raise `illegal` for one cycle instead.
- R9: After reset the decoder is in hardware mode, with table enable 0 and mask select 0. The address and instruction registers are 0, and no pulse is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cyc_n | input | 1 | Active-low cycle strobe |
| wr_n | input | 1 | Active-low write enable |
| ac_is_ctl | input | 1 | High: the control bus holds a code (hardware mode) or the data bus holds an instruction (software mode) |
| vld_ctl | input | 1 | Validity to store on memory writes |
| ac | input | 12 | Address/control bus |
| dq | input | 32 | Data bus |
| op_valid | output | 1 | One-cycle operation pulse |
| op_kind | output | 4 | Operation class code |
| op_write | output | 1 | 1 = write, 0 = read |
| op_addr | output | 12 | Memory address of the operation |
| op_reg | output | 4 | Register index of a register operation |
| op_data | output | 32 | Data word captured with the strobe |
| op_vbit | output | 1 | Validity bit for a memory write |
| illegal | output | 1 | One-cycle pulse for an unused code |
| cfg_sw_mode | output | 1 | Software mode selected |
| cfg_tbl_en | output | 1 | Lookup table enabled |
| cfg_mask_sel | output | 3 | Mask select for direct writes |

## Verification
Every operation result and every `illegal` pulse is due exactly one clock after the edge that first samples the strobe low. The driver tags each expected item with that cycle number. The monitor compares the item only at the falling edge of that cycle, and it requires the outputs to stay quiet in all other cycles, including the second held-low cycle of each strobe. Configuration changes from a register write are due on the `cfg_*` ports in the same cycle as the write's pulse. They are checked directly at that point, and again by the behaviour of the next strobe, which the bench only issues two cycles later.

// File: rtl/cam_cmd_pkg.sv
// Package: shared codes and types for the CAM command decoder.
// Assumes 4-bit operation codes and 4-bit register indices.
package cam_cmd_pkg;

    typedef enum logic [3:0] {
        K_MEM  = 4'd0,
        K_REG  = 4'd1,
        K_MOVE = 4'd2,
        K_CMP  = 4'd3,
        K_SETV = 4'd4,
        K_TBL  = 4'd5,
        K_INIT = 4'd6
    } op_kind_e;

    localparam logic [3:0] KIND_LAST = 4'd6;

    localparam logic [3:0] REG_CFG   = 4'd8;
    localparam logic [3:0] REG_ADDR  = 4'd10;
    localparam logic [3:0] REG_INSTR = 4'd12;
    localparam logic [3:0] REG_LAST  = 4'd12;

    localparam int CFG_W = 5;

    typedef struct packed {
        logic [2:0] mask_sel;
        logic       tbl_en;
        logic       sw_mode;
    } cfg_t;

endpackage

// File: rtl/cam_cmd_strobe.sv
// Module: finds the first clock edge of each active-low strobe assertion.
// Assumes the strobe is synchronous to clk.
module cam_cmd_strobe (
    input  logic clk,
    input  logic rst_n,
    input  logic cyc_n,
    output logic start
);
    logic prev_n;

    // Remember the previous strobe sample; reset counts as "high".
    always_ff @(posedge clk) begin
        if (!rst_n) prev_n <= 1'b1;
        else        prev_n <= cyc_n;
    end

    assign start = prev_n & ~cyc_n;

    a_r1_no_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !start);

endmodule

// File: rtl/cam_cmd_decode.sv
// Module: combinational decode of one bus cycle into an operation.
// Assumes the caller qualifies fire/bad/load_instr with the strobe start.
module cam_cmd_decode
    import cam_cmd_pkg::*;
#(
    parameter int AW = 12,
    parameter int IW = 8
) (
    input  logic          sw_mode,
    input  logic          ac_is_ctl,
    input  logic          wr_n,
    input  logic [AW-1:0] ac,
    input  logic [IW-1:0] instr,
    input  logic [AW-1:0] addr_reg,
    output logic          fire,
    output logic          bad,
    output logic          load_instr,
    output op_kind_e      kind,
    output logic [AW-1:0] addr,
    output logic [3:0]    regidx
);
    logic       use_code;
    logic [3:0] code;
    logic [3:0] oprnd;

    // Pick the opcode source by mode and classify the cycle.
    always_comb begin
        fire       = 1'b0;
        bad        = 1'b0;
        load_instr = 1'b0;
        use_code   = 1'b0;
        kind       = K_MEM;
        addr       = ac;
        regidx     = 4'd0;
        code       = ac[3:0];
        oprnd      = ac[7:4];
        if (!sw_mode) begin
            if (ac_is_ctl) use_code = 1'b1;
            else           fire     = 1'b1;
        end else begin
            code  = instr[3:0];
            oprnd = instr[7:4];
            if (ac_is_ctl) load_instr = ~wr_n;
            else           use_code   = 1'b1;
        end
        if (use_code) begin
            addr   = addr_reg;
            regidx = oprnd;
            if (code > KIND_LAST)                      bad = 1'b1;
            else if (code == 4'(K_REG) && oprnd > REG_LAST) bad = 1'b1;
            else begin
                fire = 1'b1;
                kind = op_kind_e'(code);
            end
        end
    end

    // R8: an unused code never also issues an operation.
    always_comb begin
        a_r8_fire_or_bad: assert (!(fire && bad));
    end

endmodule

// File: rtl/cam_cmd_regs.sv
// Module: configuration, address and instruction registers of the decoder.
// Assumes write strobes are already qualified single-cycle pulses.
module cam_cmd_regs
    import cam_cmd_pkg::*;
#(
    parameter int AW = 12,
    parameter int DW = 32,
    parameter int IW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_we,
    input  logic [3:0]    reg_idx,
    input  logic          instr_ld,
    input  logic [DW-1:0] dq,
    output cfg_t          cfg,
    output logic [AW-1:0] addr_reg,
    output logic [IW-1:0] instr
);
    // Load the configuration on a write to its index.
    always_ff @(posedge clk) begin
        if (!rst_n)                             cfg <= '0;
        else if (reg_we && reg_idx == REG_CFG)  cfg <= cfg_t'(dq[CFG_W-1:0]);
    end

    // Load the indirect address register.
    always_ff @(posedge clk) begin
        if (!rst_n)                             addr_reg <= '0;
        else if (reg_we && reg_idx == REG_ADDR) addr_reg <= dq[AW-1:0];
    end

    // Load the instruction register by register write or software-mode load.
    always_ff @(posedge clk) begin
        if (!rst_n)                                          instr <= '0;
        else if (instr_ld || (reg_we && reg_idx == REG_INSTR)) instr <= dq[IW-1:0];
    end

    a_r6_instr_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !instr_ld && !(reg_we && reg_idx == REG_INSTR) |=> $stable(instr));

    a_r5_cfg_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_we && reg_idx == REG_CFG) |=> $stable(cfg));

endmodule

// File: rtl/cam_cmd_dec.sv
// Module: top of the CAM command decoder; registers one operation per strobe.
// Assumes DW >= AW and DW >= 8, synchronous inputs, active-low reset.
module cam_cmd_dec
    import cam_cmd_pkg::*;
#(
    parameter int AW = 12,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cyc_n,
    input  logic          wr_n,
    input  logic          ac_is_ctl,
    input  logic          vld_ctl,
    input  logic [AW-1:0] ac,
    input  logic [DW-1:0] dq,
    output logic          op_valid,
    output logic [3:0]    op_kind,
    output logic          op_write,
    output logic [AW-1:0] op_addr,
    output logic [3:0]    op_reg,
    output logic [DW-1:0] op_data,
    output logic          op_vbit,
    output logic          illegal,
    output logic          cfg_sw_mode,
    output logic          cfg_tbl_en,
    output logic [2:0]    cfg_mask_sel
);
    localparam int IW = 8;

    logic          start;
    logic          fire, bad, load_instr;
    op_kind_e      kind;
    logic [AW-1:0] dec_addr;
    logic [3:0]    regidx;
    cfg_t          cfg;
    logic [AW-1:0] addr_reg;
    logic [IW-1:0] instr;
    logic          issue;

    cam_cmd_strobe u_strobe (
        .clk   (clk),
        .rst_n (rst_n),
        .cyc_n (cyc_n),
        .start (start)
    );

    cam_cmd_decode #(.AW(AW), .IW(IW)) u_decode (
        .sw_mode    (cfg.sw_mode),
        .ac_is_ctl  (ac_is_ctl),
        .wr_n       (wr_n),
        .ac         (ac),
        .instr      (instr),
        .addr_reg   (addr_reg),
        .fire       (fire),
        .bad        (bad),
        .load_instr (load_instr),
        .kind       (kind),
        .addr       (dec_addr),
        .regidx     (regidx)
    );

    assign issue = start & fire;

    cam_cmd_regs #(.AW(AW), .DW(DW), .IW(IW)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .reg_we   (issue & ~wr_n & (kind == K_REG)),
        .reg_idx  (regidx),
        .instr_ld (start & load_instr),
        .dq       (dq),
        .cfg      (cfg),
        .addr_reg (addr_reg),
        .instr    (instr)
    );

    // Register the operation pulse, illegal pulse and operation payload.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_valid <= 1'b0;
            illegal  <= 1'b0;
            op_kind  <= '0;
            op_write <= 1'b0;
            op_addr  <= '0;
            op_reg   <= '0;
            op_data  <= '0;
            op_vbit  <= 1'b0;
        end else begin
            op_valid <= issue;
            illegal  <= start & bad;
            if (issue) begin
                op_kind  <= 4'(kind);
                op_write <= ~wr_n;
                op_addr  <= dec_addr;
                op_reg   <= regidx;
                op_data  <= dq;
                op_vbit  <= (kind == K_MEM) & ~wr_n & vld_ctl;
            end
        end
    end

    assign cfg_sw_mode  = cfg.sw_mode;
    assign cfg_tbl_en   = cfg.tbl_en;
    assign cfg_mask_sel = cfg.mask_sel;

    a_r1_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |=> !op_valid);

    a_r1_from_start: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid || illegal) |-> $past(start));

    a_r8_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |=> !illegal);

    a_r8_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(op_valid && illegal));

    a_r3_direct_vbit: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && op_kind == 4'(K_MEM) && op_write && !$past(cfg.sw_mode) && !$past(ac_is_ctl)
        |-> op_vbit == $past(vld_ctl));

    a_r7_indirect_addr: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && op_kind == 4'(K_MEM) && $past(cfg.sw_mode) |-> op_addr == $past(addr_reg));

endmodule

// File: tb/sim_cam_cmd_dec.sv
// Bench: scoreboard for cam_cmd_dec. A driver task queues expected results
// tagged with their due cycle; a monitor pops and compares them.
module sim_cam_cmd_dec;
    import cam_cmd_pkg::*;

    localparam int AW = 12;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cyc_n = 1'b1, wr_n = 1'b1, ac_is_ctl = 1'b0, vld_ctl = 1'b0;
    logic [AW-1:0] ac = '0;
    logic [DW-1:0] dq = '0;
    logic          op_valid, op_write, op_vbit, illegal;
    logic [3:0]    op_kind, op_reg;
    logic [AW-1:0] op_addr;
    logic [DW-1:0] op_data;
    logic          cfg_sw_mode, cfg_tbl_en;
    logic [2:0]    cfg_mask_sel;

    cam_cmd_dec #(.AW(AW), .DW(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .cyc_n(cyc_n), .wr_n(wr_n),
        .ac_is_ctl(ac_is_ctl), .vld_ctl(vld_ctl), .ac(ac), .dq(dq),
        .op_valid(op_valid), .op_kind(op_kind), .op_write(op_write),
        .op_addr(op_addr), .op_reg(op_reg), .op_data(op_data),
        .op_vbit(op_vbit), .illegal(illegal), .cfg_sw_mode(cfg_sw_mode),
        .cfg_tbl_en(cfg_tbl_en), .cfg_mask_sel(cfg_mask_sel)
    );

    always #5 clk = ~clk;

    typedef struct {
        int            due;
        string         tag;
        bit            quiet;
        bit            ill;
        logic [3:0]    kind;
        logic          wr;
        logic [AW-1:0] addr;
        logic [3:0]    rg;
        logic [DW-1:0] data;
        logic          vb;
    } exp_t;

    exp_t q[$];
    int   cyc = 0;
    int   vectors = 0;
    int   fails = 0;
    bit   done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    // Compare one value and report a mismatch.
    task automatic chk(input string tag, input string what, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: got %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // Monitor: at each falling edge, check a due item or require quiet outputs.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (q.size() > 0 && q[0].due == cyc) begin
                exp_t e;
                e = q.pop_front();
                vectors++;
                if (e.quiet || e.ill) begin
                    chk(e.tag, "op_valid", 32'(op_valid), 32'd0);
                    chk(e.tag, "illegal", 32'(illegal), 32'(e.ill));
                end else begin
                    chk(e.tag, "op_valid", 32'(op_valid), 32'd1);
                    chk(e.tag, "illegal", 32'(illegal), 32'd0);
                    chk(e.tag, "op_kind", 32'(op_kind), 32'(e.kind));
                    chk(e.tag, "op_write", 32'(op_write), 32'(e.wr));
                    chk(e.tag, "op_data", op_data, e.data);
                    if (e.kind == 4'(K_MEM)) begin
                        chk(e.tag, "op_addr", 32'(op_addr), 32'(e.addr));
                        chk(e.tag, "op_vbit", 32'(op_vbit), 32'(e.vb));
                    end
                    if (e.kind == 4'(K_REG))
                        chk(e.tag, "op_reg", 32'(op_reg), 32'(e.rg));
                end
            end else if (op_valid || illegal) begin
                vectors++;
                fails++;
                $display("FAIL R1 spurious pulse: got valid=%0b illegal=%0b expected 0 0", op_valid, illegal);
            end
        end
    end

    // Driver: one strobe held low for two cycles, then high for one.
    task automatic strobe(input bit ctl, input bit wr, input bit vb, input logic [AW-1:0] a,
                          input logic [DW-1:0] d, input exp_t e);
        ac_is_ctl = ctl; wr_n = ~wr; vld_ctl = vb; ac = a; dq = d; cyc_n = 1'b0;
        e.due = cyc + 1;
        q.push_back(e);
        @(negedge clk);
        @(negedge clk);
        cyc_n = 1'b1;
        @(negedge clk);
    endtask

    function automatic exp_t op(input string tag, input logic [3:0] k, input bit wr,
                                input logic [AW-1:0] a, input logic [3:0] rg,
                                input logic [DW-1:0] d, input bit vb);
        exp_t e;
        e.due = 0; e.tag = tag; e.quiet = 1'b0; e.ill = 1'b0;
        e.kind = k; e.wr = wr; e.addr = a; e.rg = rg; e.data = d; e.vb = vb;
        return e;
    endfunction

    function automatic exp_t none(input string tag, input bit is_ill);
        exp_t e;
        e = op(tag, 4'd0, 1'b0, '0, 4'd0, '0, 1'b0);
        e.quiet = ~is_ill; e.ill = is_ill;
        return e;
    endfunction

    // Check the configuration outputs directly.
    task automatic chk_cfg(input string tag, input bit sw, input bit tb, input logic [2:0] m);
        vectors++;
        chk(tag, "cfg_sw_mode", 32'(cfg_sw_mode), 32'(sw));
        chk(tag, "cfg_tbl_en", 32'(cfg_tbl_en), 32'(tb));
        chk(tag, "cfg_mask_sel", 32'(cfg_mask_sel), 32'(m));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9: reset state
        chk_cfg("R9", 1'b0, 1'b0, 3'd0);
        vectors++;
        chk("R9", "op_valid", 32'(op_valid), 32'd0);
        chk("R9", "illegal", 32'(illegal), 32'd0);
        // R7/R9: indirect memory op before any address write uses address 0
        strobe(1, 0, 0, 12'h000, 32'h11, op("R9", 4'(K_MEM), 0, 12'h000, 0, 32'h11, 0));

        // R1 R2 R3: direct write with validity 1, held strobe gives one pulse
        strobe(0, 1, 1, 12'h5A3, 32'hDEADBEEF, op("R2", 4'(K_MEM), 1, 12'h5A3, 0, 32'hDEADBEEF, 1));
        // R3: direct read reports vbit 0
        strobe(0, 0, 1, 12'hFFF, 32'h0, op("R3", 4'(K_MEM), 0, 12'hFFF, 0, 32'h0, 0));
        // R3: direct write with validity 0
        strobe(0, 1, 0, 12'h001, 32'hCAFE, op("R3", 4'(K_MEM), 1, 12'h001, 0, 32'hCAFE, 0));

        // R4: control codes in hardware mode
        strobe(1, 0, 0, 12'h003, 32'h1234, op("R4", 4'(K_CMP), 0, 0, 0, 32'h1234, 0));
        strobe(1, 1, 0, 12'h031, 32'hFF00FF00, op("R4", 4'(K_REG), 1, 0, 4'd3, 32'hFF00FF00, 0));
        strobe(1, 0, 0, 12'h0C1, 32'h7, op("R4", 4'(K_REG), 0, 0, 4'd12, 32'h7, 0));
        strobe(1, 1, 0, 12'h002, 32'h2, op("R4", 4'(K_MOVE), 1, 0, 0, 32'h2, 0));
        strobe(1, 1, 0, 12'h004, 32'h4, op("R4", 4'(K_SETV), 1, 0, 0, 32'h4, 0));
        strobe(1, 1, 0, 12'h005, 32'h5, op("R4", 4'(K_TBL), 1, 0, 0, 32'h5, 0));
        strobe(1, 1, 0, 12'h006, 32'h6, op("R4", 4'(K_INIT), 1, 0, 0, 32'h6, 0));

        // R8: unused opcodes and register indices
        strobe(1, 0, 0, 12'h007, 32'h0, none("R8", 1));
        strobe(1, 1, 0, 12'h00F, 32'h0, none("R8", 1));
        strobe(1, 1, 0, 12'h0D1, 32'h0, none("R8", 1));

        // R5 R7: load address register, then indirect memory op ignores ac
        strobe(1, 1, 0, 12'h0A1, 32'h00000123, op("R5", 4'(K_REG), 1, 0, 4'd10, 32'h123, 0));
        strobe(1, 0, 0, 12'hEE0, 32'h9, op("R7", 4'(K_MEM), 0, 12'h123, 0, 32'h9, 0));

        // R5: configuration write: mask 7, table 0, software mode 1
        ac_is_ctl = 1; wr_n = 0; vld_ctl = 0; ac = 12'h081; dq = 32'h1D; cyc_n = 1'b0;
        q.push_back(op("R5", 4'(K_REG), 1, 0, 4'd8, 32'h1D, 0));
        q[$].due = cyc + 1;
        @(negedge clk);
        chk_cfg("R5", 1'b1, 1'b0, 3'd7);
        @(negedge clk);
        cyc_n = 1'b1;
        @(negedge clk);

        // R6: instruction load in software mode issues nothing
        strobe(1, 1, 0, 12'hFFF, 32'h03, none("R6", 0));
        // R6: data cycle executes compare with dq as data
        strobe(0, 0, 0, 12'hABC, 32'h55, op("R6", 4'(K_CMP), 0, 0, 0, 32'h55, 0));
        // R6: control-select read in software mode does nothing
        strobe(1, 0, 0, 12'h000, 32'h00, none("R6", 0));
        // R6: that read left the instruction in place
        strobe(0, 1, 0, 12'h000, 32'h66, op("R6", 4'(K_CMP), 1, 0, 0, 32'h66, 0));
        // R7: software-mode memory write uses the address register
        strobe(1, 1, 0, 12'h000, 32'h00, none("R7", 0));
        strobe(0, 1, 1, 12'h777, 32'hA5A5, op("R7", 4'(K_MEM), 1, 12'h123, 0, 32'hA5A5, 1));
        // R8: unused opcode held in the instruction register
        strobe(1, 1, 0, 12'h000, 32'h09, none("R8", 0));
        strobe(0, 0, 0, 12'h000, 32'h00, none("R8", 1));
        // R5: back to hardware mode with table enable via instruction
        strobe(1, 1, 0, 12'h000, 32'h81, none("R5", 0));
        strobe(0, 1, 0, 12'h000, 32'h02, op("R5", 4'(K_REG), 1, 0, 4'd8, 32'h02, 0));
        chk_cfg("R5", 1'b0, 1'b1, 3'd0);
        // R2: direct access works again in hardware mode
        strobe(0, 0, 0, 12'h3C3, 32'hBEEF, op("R2", 4'(K_MEM), 0, 12'h3C3, 0, 32'hBEEF, 0));

        repeat (3) @(negedge clk);
        if (q.size() != 0) begin
            fails++;
            $display("FAIL R1 missing results: got %0d pending expected 0", q.size());
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #200000;
        if (!done) begin
            done = 1'b1;
            fails++;
            $display("FAIL R1 watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

endmodule